// File: doc/BRIEF.md
# Audio Subframe Non-Audio Bit Stager

This block builds the 32-bit subframes of a two-channel serial audio transmitter. Each frame carries a channel A subframe and then a channel B subframe. Every subframe holds a 4-bit preamble slot, a 24-bit audio word, and validity, user and channel-status flags. The last bit is an even parity bit. Software sets the six flags through a small register port. One audio pair enters per frame on a valid/ready input. The output is one serial bit stream, LSB first, on a valid/ready output with a frame strobe and a channel marker.

The flags follow next-frame semantics. At the instant a frame starts, the channel A flags go straight into the shifter with the channel A word. At that same instant, the channel B flags and the channel B word are copied into a 3-bit plus 24-bit staging buffer. Software may therefore rewrite the flag register as soon as the frame starts. The staged channel B content is moved into the shifter when the last channel A bit leaves.

Back-pressure rules: `aud_ready` is high only while the block is enabled and at a frame boundary (idle, or the last channel B bit being accepted); one pair is taken per handshake. While `sdo_valid` is high and `sdo_ready` is low, the output bit, strobe and channel marker hold still. `sdo_valid` never waits on `sdo_ready`. If no pair is offered at a boundary, `sdo_valid` drops until one is.

Top module: `sfstg_top`

## Requirements
- R1: Subframe bit k is sent k-th (LSB first). Bits 4..27 carry the audio word, LSB at bit 4. Bit 28 is validity, bit 29 is user, bit 30 is channel status. Bit 31 makes bits 4..31 even parity.
- R2: Bits 0..3 carry a preamble code. Channel A uses 4'h3 in a block-start frame and 4'h5 in other frames. Channel B uses 4'h9. The first frame after enabling is a block start, and so is every FRAMES_PER_BLOCK-th frame after it.
- R3: The channel A flags are sampled from the register when a frame's audio pair is accepted. A write made after that point takes effect in the next frame.
- R4: The channel B flags are staged when the frame's audio pair is accepted. A write during channel A does not change the channel B subframe of the same frame.
- R5: `aud_ready` is high only when enabled and at a frame boundary. With no pair offered at a boundary, `sdo_valid` is low until one is accepted.
- R6: While `sdo_valid` is high and `sdo_ready` is low, `sdo_valid`, `sdo_data`, `sdo_frame` and `sdo_sub_b` hold their values.
- R7: `sdo_frame` is high only with bit 0 of a channel A subframe. `sdo_sub_b` is high for all 32 channel B bits and low otherwise.
- R8: Address 0 is control, with the enable in bit 0. Address 1 holds the flags: bit 0 A validity, bit 1 A user, bit 2 A status, bit 3 B validity, bit 4 B user, bit 5 B status. All other bits read 0. The staging buffer cannot be read.
- R9: Hardware reset clears both registers. `soft_rst` clears the control register only and keeps the flag register.
- R10: While disabled, `sdo_valid` is low from the next cycle on and any frame in flight is dropped. The frame count restarts, so the first frame after re-enabling is a block start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| soft_rst | input | 1 | Software reset pulse, clears control |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = flags |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Read data of the addressed register |
| aud_valid | input | 1 | Audio pair offered |
| aud_ready | output | 1 | Audio pair accepted this cycle when valid |
| aud_a | input | 24 | Channel A audio word |
| aud_b | input | 24 | Channel B audio word |
| sdo_valid | output | 1 | Serial bit valid |
| sdo_ready | input | 1 | Downstream takes the bit |
| sdo_data | output | 1 | Serial subframe bit |
| sdo_frame | output | 1 | First bit of a frame |
| sdo_sub_b | output | 1 | Bit belongs to channel B |

## Verification
The assertions assume that `rst_n` is held low for at least one edge and that `soft_rst` is a plain synchronous pulse. They also assume the downstream may lower `sdo_ready` at any cycle. The stimulus drives every input one time unit after the rising edge. It toggles `sdo_ready` pseudo-randomly and leaves gaps between audio pairs. Register writes never fall on the cycle in which a pair is accepted, so the bench's flag model always knows which value a frame sampled.

// File: rtl/sfstg_pkg.sv
package sfstg_pkg;
  localparam int SUB_W   = 32;
  localparam int AUD_W   = 24;
  localparam int AUD_LSB = 4;
  localparam int V_POS   = 28;
  localparam int U_POS   = 29;
  localparam int C_POS   = 30;
  localparam int P_POS   = 31;
  localparam int NAD_W   = 6;

  localparam logic [3:0] PRE_A_BLK = 4'h3;
  localparam logic [3:0] PRE_A     = 4'h5;
  localparam logic [3:0] PRE_B     = 4'h9;

  typedef struct packed {
    logic c;
    logic u;
    logic v;
  } nad_t;

  function automatic logic [SUB_W-1:0] build_sub(input logic [3:0] pre,
                                                 input logic [AUD_W-1:0] aud,
                                                 input nad_t n);
    logic [SUB_W-1:0] s;
    s = '0;
    s[3:0] = pre;
    s[AUD_LSB +: AUD_W] = aud;
    s[V_POS] = n.v;
    s[U_POS] = n.u;
    s[C_POS] = n.c;
    s[P_POS] = ^s[C_POS:AUD_LSB];
    return s;
  endfunction
endpackage

// File: rtl/sfstg_regs.sv
module sfstg_regs
  import sfstg_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             we,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             en,
  output nad_t             nad_a,
  output nad_t             nad_b
);
  localparam int PAD_W = REG_W - NAD_W;

  logic             ctrl_en;
  logic [NAD_W-1:0] nad_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
    end else if (soft_rst) begin
      ctrl_en <= 1'b0;
    end else if (we && !addr) begin
      ctrl_en <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nad_q <= '0;
    end else if (we && addr) begin
      nad_q <= wdata[NAD_W-1:0];
    end
  end

  always_comb begin
    if (addr) rdata = {{PAD_W{1'b0}}, nad_q};
    else      rdata = {{(REG_W-1){1'b0}}, ctrl_en};
  end

  assign en    = ctrl_en;
  assign nad_a = nad_t'(nad_q[2:0]);
  assign nad_b = nad_t'(nad_q[5:3]);

  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !en);

  // R8
  nad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr) |=> $stable({nad_a, nad_b}));
endmodule

// File: rtl/sfstg_hold.sv
module sfstg_hold
  import sfstg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AUD_W-1:0] aud_in,
  input  nad_t             nad_in,
  output logic [AUD_W-1:0] aud_q,
  output nad_t             nad_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aud_q <= '0;
      nad_q <= '0;
    end else if (load) begin
      aud_q <= aud_in;
      nad_q <= nad_in;
    end
  end

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({aud_q, nad_q}));
endmodule

// File: rtl/sfstg_ser.sv
module sfstg_ser
  import sfstg_pkg::*;
#(
  parameter int FPB = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             aud_valid,
  output logic             aud_ready,
  input  logic [AUD_W-1:0] aud_a,
  input  nad_t             nad_a,
  input  logic [AUD_W-1:0] hold_aud,
  input  nad_t             hold_nad,
  output logic             hold_load,
  output logic             sdo_valid,
  input  logic             sdo_ready,
  output logic             sdo_data,
  output logic             sdo_frame,
  output logic             sdo_sub_b
);
  localparam int FCW = (FPB > 1) ? $clog2(FPB) : 1;
  localparam int BCW = $clog2(SUB_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(SUB_W - 1);
  localparam logic [FCW-1:0] LAST_FR  = FCW'(FPB - 1);

  logic             busy, chan_b;
  logic [BCW-1:0]   bcnt;
  logic [SUB_W-1:0] shreg;
  logic [FCW-1:0]   fcnt;
  logic             fire, last, boundary, start;
  logic [3:0]       pre_a;

  assign fire     = busy && sdo_ready;
  assign last     = fire && (bcnt == LAST_BIT);
  assign boundary = !busy || (last && chan_b);
  assign aud_ready = en && boundary;
  assign start    = aud_ready && aud_valid;
  assign hold_load = start;
  assign pre_a    = (fcnt == '0) ? PRE_A_BLK : PRE_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      chan_b <= 1'b0;
      bcnt   <= '0;
      shreg  <= '0;
      fcnt   <= '0;
    end else if (!en) begin
      busy   <= 1'b0;
      chan_b <= 1'b0;
      bcnt   <= '0;
      fcnt   <= '0;
    end else if (start) begin
      shreg  <= build_sub(pre_a, aud_a, nad_a);
      busy   <= 1'b1;
      chan_b <= 1'b0;
      bcnt   <= '0;
      fcnt   <= (fcnt == LAST_FR) ? '0 : fcnt + 1'b1;
    end else if (last && !chan_b) begin
      shreg  <= build_sub(PRE_B, hold_aud, hold_nad);
      chan_b <= 1'b1;
      bcnt   <= '0;
    end else if (last) begin
      busy   <= 1'b0;
      chan_b <= 1'b0;
      bcnt   <= '0;
    end else if (fire) begin
      shreg  <= shreg >> 1;
      bcnt   <= bcnt + 1'b1;
    end
  end

  assign sdo_valid = busy;
  assign sdo_data  = shreg[0];
  assign sdo_frame = busy && !chan_b && (bcnt == '0);
  assign sdo_sub_b = busy && chan_b;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_valid && !sdo_ready && en) |=>
      (sdo_valid && $stable(sdo_data) && $stable(sdo_frame) && $stable(sdo_sub_b)));

  // R5
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aud_ready |-> (en && (!sdo_valid || (sdo_ready && sdo_sub_b))));

  // R10
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sdo_valid);

  // R7
  frame_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_frame |-> (sdo_valid && !sdo_sub_b));

  // R7
  b_follows_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_sub_b) |-> $past(sdo_valid && !sdo_sub_b && sdo_ready));
endmodule

// File: rtl/sfstg_top.sv
module sfstg_top
  import sfstg_pkg::*;
#(
  parameter int REG_W            = 16,
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             aud_valid,
  output logic             aud_ready,
  input  logic [23:0]      aud_a,
  input  logic [23:0]      aud_b,
  output logic             sdo_valid,
  input  logic             sdo_ready,
  output logic             sdo_data,
  output logic             sdo_frame,
  output logic             sdo_sub_b
);
  logic             en, hold_load;
  nad_t             nad_a, nad_b, hold_nad;
  logic [AUD_W-1:0] hold_aud;

  sfstg_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .en(en), .nad_a(nad_a), .nad_b(nad_b)
  );

  sfstg_hold u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load),
    .aud_in(aud_b), .nad_in(nad_b),
    .aud_q(hold_aud), .nad_q(hold_nad)
  );

  sfstg_ser #(.FPB(FRAMES_PER_BLOCK)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(en),
    .aud_valid(aud_valid), .aud_ready(aud_ready), .aud_a(aud_a), .nad_a(nad_a),
    .hold_aud(hold_aud), .hold_nad(hold_nad), .hold_load(hold_load),
    .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
    .sdo_frame(sdo_frame), .sdo_sub_b(sdo_sub_b)
  );
endmodule

// File: tb/tb_sfstg_top.sv
`timescale 1ns/1ps
module tb_sfstg_top;
  localparam int RW  = 16;
  localparam int FPB = 4;

  typedef struct {
    logic  d;
    logic  fr;
    logic  sb;
    string tag;
  } item_t;

  logic clk = 0, rst_n = 0, soft_rst = 0, reg_we = 0, reg_addr = 0;
  logic [RW-1:0] reg_wdata = '0, reg_rdata;
  logic aud_valid = 0, aud_ready, sdo_valid, sdo_ready = 1, sdo_data, sdo_frame, sdo_sub_b;
  logic [23:0] aud_a = '0, aud_b = '0;

  int n_cmp = 0, n_bad = 0;
  bit mon_on = 0, done = 0;
  item_t q[$];
  logic [5:0] nad_m = '0;
  int fr_idx = 0;
  logic [7:0] lfsr = 8'h5a;

  always #10 clk = ~clk;

  sfstg_top #(.REG_W(RW), .FRAMES_PER_BLOCK(FPB)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .aud_valid(aud_valid), .aud_ready(aud_ready), .aud_a(aud_a), .aud_b(aud_b),
    .sdo_valid(sdo_valid), .sdo_ready(sdo_ready), .sdo_data(sdo_data),
    .sdo_frame(sdo_frame), .sdo_sub_b(sdo_sub_b)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // downstream ready pattern, mostly high
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    sdo_ready = (lfsr[2:0] != 3'b000);
  end

  // scoreboard monitor
  logic prev_stall = 0, prev_d = 0;
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (prev_stall) begin
        // R6
        chk(sdo_valid === 1'b1 && sdo_data === prev_d, "R6", "held bit",
            {sdo_valid, sdo_data}, {1'b1, prev_d});
      end
      if (sdo_valid && sdo_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5", "bit with empty queue", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(sdo_data === it.d, it.tag, "bit", sdo_data, it.d);
          // R7
          chk(sdo_frame === it.fr && sdo_sub_b === it.sb, "R7", "strobe/channel",
              {sdo_frame, sdo_sub_b}, {it.fr, it.sb});
        end
      end
      prev_stall = sdo_valid && !sdo_ready;
      prev_d     = sdo_data;
    end else begin
      prev_stall = 0;
    end
  end

  function automatic logic [31:0] mk_sub(input logic [3:0] pre, input logic [23:0] a,
                                         input logic [2:0] vuc);
    logic [31:0] s;
    logic p;
    s = {1'b0, vuc[2], vuc[1], vuc[0], a, pre};
    p = 1'b0;
    for (int i = 4; i < 31; i++) p = p ^ s[i];
    s[31] = p;
    return s;
  endfunction

  task automatic push_frame(input logic [23:0] a, input logic [23:0] b,
                            input logic [5:0] flags, input bit blk);
    logic [31:0] sa, sb;
    item_t it;
    sa = mk_sub(blk ? 4'h3 : 4'h5, a, flags[2:0]);
    sb = mk_sub(4'h9, b, flags[5:3]);
    for (int i = 0; i < 32; i++) begin
      it.d = sa[i]; it.fr = (i == 0); it.sb = 1'b0;
      it.tag = (i < 4) ? "R2" : (i >= 28 && i <= 30) ? "R3" : "R1";
      q.push_back(it);
    end
    for (int i = 0; i < 32; i++) begin
      it.d = sb[i]; it.fr = 1'b0; it.sb = 1'b1;
      it.tag = (i < 4) ? "R2" : (i >= 28 && i <= 30) ? "R4" : "R1";
      q.push_back(it);
    end
  endtask

  task automatic reg_write(input logic addr, input logic [RW-1:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = addr; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
    if (addr) nad_m = d[5:0];
  endtask

  task automatic reg_read(input logic addr, output logic [RW-1:0] d);
    @(posedge clk); #1;
    reg_addr = addr;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // driver: offer a pair, wait for acceptance, push expected bits
  task automatic send_pair(input logic [23:0] a, input logic [23:0] b);
    logic [5:0] flags;
    bit blk;
    @(posedge clk); #1;
    aud_a = a; aud_b = b; aud_valid = 1;
    do @(negedge clk); while (!aud_ready);
    flags = nad_m;
    blk = (fr_idx % FPB) == 0;
    fr_idx++;
    push_frame(a, b, flags, blk);
    @(posedge clk); #1;
    aud_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] rd;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk(sdo_valid === 1'b0 && aud_ready === 1'b0, "R9", "idle after reset",
        {sdo_valid, aud_ready}, 0);
    reg_read(1'b0, rd); chk(rd === '0, "R9", "ctrl after reset", rd, 0);
    reg_read(1'b1, rd); chk(rd === '0, "R9", "flags after reset", rd, 0);
    // R8 readback and unused bits
    reg_write(1'b1, 16'hffff);
    reg_read(1'b1, rd); chk(rd === 16'h003f, "R8", "flags readback", rd, 16'h3f);
    reg_write(1'b0, 16'hfffe);
    reg_read(1'b0, rd); chk(rd === 16'h0000, "R8", "ctrl bit0 clear", rd, 0);
    reg_write(1'b1, 16'h0015);
    // R5 disabled: no ready
    @(negedge clk); chk(aud_ready === 1'b0, "R5", "ready while off", aud_ready, 0);

    mon_on = 1;
    fr_idx = 0;
    reg_write(1'b0, 16'h0001);
    for (int k = 0; k < 10; k++) begin
      send_pair($urandom & 24'hffffff, $urandom & 24'hffffff);
      if (k % 2 == 0) begin
        repeat (5) @(posedge clk);
        // R3 R4: write lands mid channel A
        reg_write(1'b1, 16'($urandom & 32'h3f));
      end
      if (k == 3) begin
        wait (q.size() == 0);
        @(posedge clk); @(negedge clk);
        // R5 gap: output idles, block waits for a pair
        chk(sdo_valid === 1'b0 && aud_ready === 1'b1, "R5", "idle gap",
            {sdo_valid, aud_ready}, 2'b01);
      end
    end
    wait (q.size() == 0);
    repeat (4) @(posedge clk);

    // R9 R10: soft reset during a frame
    mon_on = 0;
    send_pair(24'h123456, 24'h654321);
    repeat (10) @(posedge clk);
    #1 soft_rst = 1;
    @(posedge clk); #1 soft_rst = 0;
    @(posedge clk);
    @(negedge clk);
    chk(sdo_valid === 1'b0, "R10", "frame dropped", sdo_valid, 0);
    reg_read(1'b0, rd); chk(rd === '0, "R9", "ctrl after soft reset", rd, 0);
    reg_read(1'b1, rd); chk(rd === {10'b0, nad_m}, "R9", "flags kept", rd, nad_m);
    q.delete();
    fr_idx = 0;
    mon_on = 1;
    reg_write(1'b0, 16'h0001);
    // R10: first frame after re-enable carries block code
    send_pair(24'habcdef, 24'h0f0f0f);
    send_pair(24'h000001, 24'h800000);
    wait (q.size() == 0);
    repeat (4) @(posedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule